// File: doc/BRIEF.md
# Crossbar Two-Phase Read Sequencer

This block steers a single access to a resistive crossbar array through a shared sense-and-hold circuit. A caller presents a request: read or write, a row, a column, the value to write, and a flag saying the held background sample may be reused. The block then drives a bias code for every wordline and every bitline, the bitline precharge enable, the switch that connects the bitline to the hold capacitor (sample switch) and the switch that connects it to the comparator (sense switch). When the access ends it pulses a done strobe and, for a read, presents the sensed bit.

A read first precharges the bitlines. It then measures the background sneak current with the selected wordline at half bias. The sample switch opens, one idle cycle follows, and the sense switch closes while the selected wordline is raised to full read bias. When the caller asserts the skip flag, the sampling phase is left out and the read goes from precharge straight to sensing. A write applies the write voltage across the selected cell for a fixed number of cycles, with the polarity chosen by the data bit. All phase lengths are parameters counted in clock cycles. The comparator decision arrives as a digital input. The block does not judge whether a held sample is still valid.

Top module: `xbar_read_seq`

## Requirements
- R1: After reset and whenever the block is idle, busy, done, precharge, the sample switch, the sense switch and the write-rail select are all low, and every line bias code is 00 (zero). Line i occupies bits [2i+1:2i] of its bias vector. The codes are 00 zero, 01 half and 10 full.
- R2: A request is accepted only in the idle state. A request raised while busy is ignored: it changes neither the biases nor the timing of the access in progress, and it produces no done pulse.
- R3: A read spends its first PRE_CYC cycles after acceptance with precharge high, both switches open and every bias code 00.
- R4: A read without skip then spends SAMP_CYC cycles with the sample switch closed and the sense switch open. The selected wordline is at 01, the selected bitline at 00, and all other lines at 01.
- R5: The two switches are never closed in the same cycle. Between sampling and sensing there is exactly one cycle with both open and the sampling biases held.
- R6: Sensing lasts SENSE_CYC cycles with the sense switch closed. The selected wordline is at 10, the selected bitline at 00, and all other lines at 01.
- R7: done is high for one cycle, PRE_CYC+SAMP_CYC+1+SENSE_CYC cycles after the accepting edge. rd_bit then holds the comparator value of the last sensing cycle.
- R8: A read with skip goes from precharge straight to sensing. The sample switch never closes, and done comes PRE_CYC+SENSE_CYC cycles after acceptance.
- R9: A write of 1 holds the write-rail select high for WR_CYC cycles with no precharge and both switches open. The selected wordline is at 10, the selected bitline at 00, and all other lines at 01. done comes WR_CYC cycles after acceptance.
- R10: A write of 0 swaps polarity: the selected wordline is at 00 and the selected bitline at 10, with all other lines at 01.
- R11: A write leaves rd_bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Selected wordline |
| req_col | input | $clog2(COLS) | Selected bitline |
| req_wdata | input | 1 | Value to write |
| req_skip | input | 1 | Reuse the held background sample |
| cmp_in | input | 1 | Comparator decision |
| busy | output | 1 | Access in progress |
| wl_bias | output | 2*ROWS | Wordline bias codes |
| bl_bias | output | 2*COLS | Bitline bias codes |
| rail_write | output | 1 | Bias codes refer to the write voltage |
| precharge | output | 1 | Bitline precharge enable |
| s1_close | output | 1 | Sample switch closed |
| s2_close | output | 1 | Sense switch closed |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Last sensed bit |

## Verification
Every output is decoded from registered state. The bench therefore records the edge that accepts a request and predicts the full phase sequence from it: precharge in offsets 0 to PRE_CYC-1, sampling next, one gap cycle, then sensing. Done is due at PRE_CYC+SAMP_CYC+1+SENSE_CYC for a full read, PRE_CYC+SENSE_CYC for a skipped read and WR_CYC for a write. The driver checks the biases and switches on the falling edge of each of those cycles. It queues the due cycle and the expected bit, and a monitor compares them on the falling edge where done is seen. Because the next request is driven in the done cycle, back-to-back acceptance is covered as well.

// File: rtl/xbar_seq_pkg.sv
package xbar_seq_pkg;
   typedef enum logic [1:0] {
      LV_ZERO = 2'b00,
      LV_HALF = 2'b01,
      LV_FULL = 2'b10
   } lvl_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_SAMP,
      PH_GAP,
      PH_SENSE,
      PH_WRITE
   } phase_t;
endpackage

// File: rtl/xbar_seq_fsm.sv
module xbar_seq_fsm
   import xbar_seq_pkg::*;
#(
   parameter int PRE_CYC   = 2,
   parameter int SAMP_CYC  = 10,
   parameter int SENSE_CYC = 10,
   parameter int WR_CYC    = 10
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   req_write,
   input  logic   req_skip,
   output phase_t phase,
   output logic   accept,
   output logic   rd_finish,
   output logic   wr_finish,
   output logic   precharge,
   output logic   s1_close,
   output logic   s2_close
);
   localparam int M1   = (PRE_CYC > SAMP_CYC) ? PRE_CYC : SAMP_CYC;
   localparam int M2   = (SENSE_CYC > WR_CYC) ? SENSE_CYC : WR_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

   generate
      if (PRE_CYC < 1 || SAMP_CYC < 1 || SENSE_CYC < 1 || WR_CYC < 1) begin : g_bad_len
         $error("xbar_seq_fsm: every phase length must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          skip_q;
   logic          cnt_zero;

   assign cnt_zero  = (cnt == '0);
   assign accept    = (phase == PH_IDLE) && req_valid;
   assign rd_finish = (phase == PH_SENSE) && cnt_zero;
   assign wr_finish = (phase == PH_WRITE) && cnt_zero;
   assign precharge = (phase == PH_PRE);
   assign s1_close  = (phase == PH_SAMP);
   assign s2_close  = (phase == PH_SENSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         skip_q <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  skip_q <= req_skip;
                  if (req_write) begin
                     phase <= PH_WRITE;
                     cnt   <= CW'(WR_CYC - 1);
                  end else begin
                     phase <= PH_PRE;
                     cnt   <= CW'(PRE_CYC - 1);
                  end
               end
            end
            PH_PRE: begin
               if (cnt_zero) begin
                  if (skip_q) begin
                     phase <= PH_SENSE;
                     cnt   <= CW'(SENSE_CYC - 1);
                  end else begin
                     phase <= PH_SAMP;
                     cnt   <= CW'(SAMP_CYC - 1);
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_SAMP: begin
               if (cnt_zero) begin
                  phase <= PH_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_GAP: begin
               phase <= PH_SENSE;
               cnt   <= CW'(SENSE_CYC - 1);
            end
            PH_SENSE, PH_WRITE: begin
               if (cnt_zero) begin
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R5: switches are break-before-make
   a_r5_never_both_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !(s1_close && s2_close));
   a_r5_gap_before_sense: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s2_close) |-> !$past(s1_close));
   // R3/R4: sampling starts right after precharge
   a_r4_sample_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s1_close) |-> $past(precharge));
   // R3: precharge keeps both switches open
   a_r3_precharge_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
      precharge |-> (!s1_close && !s2_close));
endmodule

// File: rtl/xbar_line_bias.sv
module xbar_line_bias
   import xbar_seq_pkg::*;
#(
   parameter int N = 8,
   localparam int IW = (N < 2) ? 1 : $clog2(N)
) (
   input  logic [IW-1:0]  sel_idx,
   input  lvl_t           sel_lvl,
   input  lvl_t           oth_lvl,
   output logic [2*N-1:0] bias
);
   generate
      if (N < 2) begin : g_bad_n
         $error("xbar_line_bias: at least two lines are required");
      end
      for (genvar i = 0; i < N; i++) begin : g_line
         assign bias[2*i +: 2] = (sel_idx == IW'(i)) ? sel_lvl : oth_lvl;
      end
   endgenerate
endmodule

// File: rtl/xbar_sense_capture.sv
module xbar_sense_capture #(
   parameter bit SYNC_CMP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_in,
   input  logic rd_finish,
   input  logic wr_finish,
   output logic done,
   output logic rd_bit
);
   logic cmp_use;

   generate
      if (SYNC_CMP) begin : g_sync
         logic cmp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_q <= 1'b0;
            else        cmp_q <= cmp_in;
         end
         assign cmp_use = cmp_q;
      end else begin : g_direct
         assign cmp_use = cmp_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         rd_bit <= 1'b0;
      end else begin
         done <= rd_finish | wr_finish;
         if (rd_finish) rd_bit <= cmp_use;
      end
   end

   // R7: done is a single-cycle pulse
   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11: a write never alters the sensed bit
   a_r11_write_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_finish |=> $stable(rd_bit));
endmodule

// File: rtl/xbar_read_seq.sv
module xbar_read_seq
   import xbar_seq_pkg::*;
#(
   parameter int ROWS      = 8,
   parameter int COLS      = 8,
   parameter int PRE_CYC   = 2,
   parameter int SAMP_CYC  = 10,
   parameter int SENSE_CYC = 10,
   parameter int WR_CYC    = 10,
   parameter bit SYNC_CMP  = 1'b0,
   localparam int RIW = (ROWS < 2) ? 1 : $clog2(ROWS),
   localparam int CIW = (COLS < 2) ? 1 : $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [RIW-1:0]    req_row,
   input  logic [CIW-1:0]    req_col,
   input  logic              req_wdata,
   input  logic              req_skip,
   input  logic              cmp_in,
   output logic              busy,
   output logic [2*ROWS-1:0] wl_bias,
   output logic [2*COLS-1:0] bl_bias,
   output logic              rail_write,
   output logic              precharge,
   output logic              s1_close,
   output logic              s2_close,
   output logic              done,
   output logic              rd_bit
);
   phase_t         phase;
   logic           accept;
   logic           rd_finish;
   logic           wr_finish;
   logic [RIW-1:0] row_q;
   logic [CIW-1:0] col_q;
   logic           wdata_q;
   lvl_t           wl_sel, bl_sel, oth;

   xbar_seq_fsm #(
      .PRE_CYC  (PRE_CYC),
      .SAMP_CYC (SAMP_CYC),
      .SENSE_CYC(SENSE_CYC),
      .WR_CYC   (WR_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_skip (req_skip),
      .phase    (phase),
      .accept   (accept),
      .rd_finish(rd_finish),
      .wr_finish(wr_finish),
      .precharge(precharge),
      .s1_close (s1_close),
      .s2_close (s2_close)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= 1'b0;
      end else if (accept) begin
         row_q   <= req_row;
         col_q   <= req_col;
         wdata_q <= req_wdata;
      end
   end

   always_comb begin
      wl_sel = LV_ZERO;
      bl_sel = LV_ZERO;
      oth    = LV_ZERO;
      unique case (phase)
         PH_SAMP, PH_GAP: begin
            wl_sel = LV_HALF;
            oth    = LV_HALF;
         end
         PH_SENSE: begin
            wl_sel = LV_FULL;
            oth    = LV_HALF;
         end
         PH_WRITE: begin
            wl_sel = wdata_q ? LV_FULL : LV_ZERO;
            bl_sel = wdata_q ? LV_ZERO : LV_FULL;
            oth    = LV_HALF;
         end
         default: ;
      endcase
   end

   xbar_line_bias #(.N(ROWS)) u_wl (
      .sel_idx(row_q),
      .sel_lvl(wl_sel),
      .oth_lvl(oth),
      .bias   (wl_bias)
   );

   xbar_line_bias #(.N(COLS)) u_bl (
      .sel_idx(col_q),
      .sel_lvl(bl_sel),
      .oth_lvl(oth),
      .bias   (bl_bias)
   );

   xbar_sense_capture #(.SYNC_CMP(SYNC_CMP)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_in   (cmp_in),
      .rd_finish(rd_finish),
      .wr_finish(wr_finish),
      .done     (done),
      .rd_bit   (rd_bit)
   );

   assign busy       = (phase != PH_IDLE);
   assign rail_write = (phase == PH_WRITE);

   // R9: write biasing keeps the sense path disconnected
   a_r9_write_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
      rail_write |-> (!s1_close && !s2_close && !precharge));
   // R3: an accepted read starts with precharge
   a_r3_read_starts_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write) |=> precharge);
   // R2: a request while busy does not disturb the latched address
   a_r2_busy_ignores_request: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(row_q) && $stable(col_q) && $stable(wdata_q)));
endmodule

// File: tb/tb_xbar_read_seq.sv
module tb_xbar_read_seq;
   localparam int N     = 8;
   localparam int PRE   = 2;
   localparam int SAMP  = 10;
   localparam int SENSE = 10;
   localparam int WR    = 10;
   localparam logic [1:0] Z = 2'b00, H = 2'b01, F = 2'b10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_write = 0, req_wdata = 0, req_skip = 0, cmp_in = 0;
   logic [2:0] req_row = '0, req_col = '0;
   logic busy, rail_write, precharge, s1_close, s2_close, done, rd_bit;
   logic [2*N-1:0] wl_bias, bl_bias;

   int cyc = 0, checks = 0, errors = 0;
   bit finished = 0;
   logic last_bit = 1'b0;

   typedef struct { int due; logic bval; } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;   // 200 MHz
   always @(posedge clk) cyc <= cyc + 1;

   xbar_read_seq #(
      .ROWS(N), .COLS(N), .PRE_CYC(PRE), .SAMP_CYC(SAMP),
      .SENSE_CYC(SENSE), .WR_CYC(WR), .SYNC_CMP(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .req_skip(req_skip), .cmp_in(cmp_in), .busy(busy), .wl_bias(wl_bias),
      .bl_bias(bl_bias), .rail_write(rail_write), .precharge(precharge),
      .s1_close(s1_close), .s2_close(s2_close), .done(done), .rd_bit(rd_bit)
   );

   function automatic logic [2*N-1:0] vec(int sel, logic [1:0] s, logic [1:0] o);
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) r[2*i +: 2] = (i == sel) ? s : o;
      return r;
   endfunction

   task automatic check_out(string tag, logic [2*N-1:0] ewl, logic [2*N-1:0] ebl,
                            logic pre, logic s1, logic s2, logic rw, logic bz);
      logic [2*(2*N)+4:0] got, exp;
      got = {wl_bias, bl_bias, precharge, s1_close, s2_close, rail_write, busy};
      exp = {ewl, ebl, pre, s1, s2, rw, bz};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
      end
   endtask

   // monitor: pops expected completions when done appears
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R2/R7 unexpected done at cycle %0d: got 1 expected 0", cyc);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (cyc != e.due || rd_bit !== e.bval) begin
               errors++;
               $display("FAIL R7/R8/R9/R11 done: got cycle %0d bit %b expected cycle %0d bit %b",
                        cyc, rd_bit, e.due, e.bval);
            end
         end
      end
   end

   task automatic run_op(bit wr, int row, int col, bit wd, bit skip, bit b, bit intrude);
      int acc, total;
      exp_t e;
      string tag;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_row = 3'(row); req_col = 3'(col);
      req_wdata = wd; req_skip = skip; cmp_in = b;
      acc   = cyc + 1;
      total = wr ? WR : (skip ? PRE + SENSE : PRE + SAMP + 1 + SENSE);
      e.due  = acc + total;
      e.bval = wr ? last_bit : b;
      sb.push_back(e);
      if (!wr) last_bit = b;
      for (int j = 0; j < total; j++) begin
         @(negedge clk);
         if (j == 0) req_valid = 0;
         if (intrude && j == 3) begin
            req_valid = 1; req_write = 1; req_row = 3'(row ^ 5); req_col = 3'(col ^ 3);
            req_wdata = 0; req_skip = 1;
         end
         if (intrude && j == 4) req_valid = 0;
         if (wr) begin
            tag = wd ? "R9" : "R10";
            check_out(tag, vec(row, wd ? F : Z, H), vec(col, wd ? Z : F, H), 0, 0, 0, 1, 1);
         end else if (j < PRE) begin
            tag = intrude ? "R2" : "R3";
            check_out(tag, vec(0, Z, Z), vec(0, Z, Z), 1, 0, 0, 0, 1);
         end else if (!skip && j < PRE + SAMP) begin
            tag = intrude ? "R2" : "R4";
            check_out(tag, vec(row, H, H), vec(col, Z, H), 0, 1, 0, 0, 1);
         end else if (!skip && j == PRE + SAMP) begin
            check_out("R5", vec(row, H, H), vec(col, Z, H), 0, 0, 0, 0, 1);
         end else begin
            tag = skip ? "R8" : (intrude ? "R2" : "R6");
            check_out(tag, vec(row, F, H), vec(col, Z, H), 0, 0, 1, 0, 1);
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_out("R1", vec(0, Z, Z), vec(0, Z, Z), 0, 0, 0, 0, 0);
      rst_n = 1;
      @(negedge clk);
      check_out("R1", vec(0, Z, Z), vec(0, Z, Z), 0, 0, 0, 0, 0);
      run_op(0, 2, 5, 0, 0, 1, 0);   // R4 R6 R7 full read of a 1
      run_op(0, 7, 0, 0, 0, 0, 0);   // R7 full read of a 0, back to back
      run_op(0, 0, 7, 0, 1, 1, 0);   // R8 skipped sampling
      run_op(1, 3, 3, 1, 0, 0, 0);   // R9 write 1, R11 rd_bit kept
      run_op(1, 6, 1, 0, 0, 1, 0);   // R10 write 0, R11 rd_bit kept
      run_op(0, 4, 2, 0, 0, 0, 1);   // R2 request while busy is ignored
      run_op(0, 5, 6, 0, 1, 0, 0);   // R8 skipped read of a 0
      repeat (4) @(negedge clk);
      check_out("R1", vec(0, Z, Z), vec(0, Z, Z), 0, 0, 0, 0, 0);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R7 missing done: got %0d pending expected 0", sb.size());
      end
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule